// File: doc/BRIEF.md
# Multi-Channel Prescaled Reload Timer

This block holds several independent down-counters that share one clock. Each channel has its own power-of-two prescaler, a running count and a separate reload value. A channel counts only while its bit in a common run register is set. When a prescaled tick arrives and the count already holds zero, the channel loads its reload value, latches a sticky underflow flag and, if its interrupt enable is set, raises its interrupt line.

Software reaches every register through a flat word-addressed port: one write strobe, an address, write data and combinational read data. Address 0 is the run register. Each channel then takes three consecutive words starting at 1 + 3*c: count, reload, control. Control bits [2:0] pick the prescale, bit 3 enables the interrupt and bit 4 is the underflow flag. Unmapped addresses read as zero.

Top module: `reload_timer`

## Requirements
- R1: Channel c advances only while bit c of the run register (address 0) is 1. When that bit is 0 the count holds its value.
- R2: Prescale codes 0 to 4 give one tick every 4, 16, 64, 256 and 1024 clocks. A 0-to-1 write of a run bit clears that channel's prescale remainder. The first count change therefore lands exactly 2^shift clocks after the start write. Remainders carry over between ticks, so no clock is lost.
- R3: On a tick with a nonzero count, the count decrements by one.
- R4: On a tick with a count of zero, the count loads the reload value (address 2 + 3*c) instead of wrapping.
- R5: That underflow sets control bit 4. irq_o[c] equals control bit 4 AND control bit 3.
- R6: The flag is sticky. A control write with bit 4 = 0 clears it. A control write with bit 4 = 1 leaves it unchanged. If an underflow and a clearing write fall in the same cycle, the flag ends up set.
- R7: Writing the reload value never changes the running count, whether the channel is stopped or running.
- R8: If a software count write (address 1 + 3*c) and a tick fall in the same cycle, the written value is kept. An underflow in that cycle still sets the flag.
- R9: Prescale codes 5, 6 and 7 are reserved and stop the channel even when its run bit is set.
- R10: After reset every register reads zero and every irq_o bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W (4) | Word address |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data for addr_i, combinational |
| irq_o | output | NUM_CH (3) | Per-channel interrupt request |

## Verification
The bench uses the default build: three channels, 32-bit counters and five prescale codes, with the largest shift being 10. Three channels are enough to run channels with different codes at the same time, so the bench can see whether one channel's prescaler or flag leaks into another. The 1024-clock period is short enough to test the exact tick boundary at 1023 and 1024 clocks. Small random counts and reload values make several reloads fit into a run of a few hundred clocks.

// File: rtl/rt_pkg.sv
package rt_pkg;
  localparam int SEL_W      = 3;
  localparam int SEL_LSB    = 0;
  localparam int IE_BIT     = 3;
  localparam int UF_BIT     = 4;
  localparam int CTRL_W     = 5;
  localparam int REGS_PER_CH = 3;
  localparam int OFS_CNT    = 0;
  localparam int OFS_RLD    = 1;
  localparam int OFS_CTRL   = 2;

  function automatic int ch_addr(int ch, int ofs);
    return 1 + REGS_PER_CH * ch + ofs;
  endfunction
endpackage

// File: rtl/rt_prescaler.sv
module rt_prescaler #(
  parameter int SEL_W      = 3,
  parameter int NUM_SEL    = 5,
  parameter int SHIFT_BASE = 2,
  parameter int SHIFT_STEP = 2,
  localparam int PRE_W     = SHIFT_BASE + SHIFT_STEP * (NUM_SEL - 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] pre_q, mask;
  logic             sel_ok;
  int               shift;

  always_comb begin
    sel_ok = ({1'b0, sel_i} < (SEL_W+1)'(NUM_SEL));
    shift  = SHIFT_BASE + SHIFT_STEP * int'(sel_i);
    for (int i = 0; i < PRE_W; i++) mask[i] = (i < shift);
    tick_o = run_i && sel_ok && ((pre_q & mask) == mask);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pre_q <= '0;
    else if (restart_i)         pre_q <= '0;
    else if (run_i && sel_ok)   pre_q <= (pre_q + 1'b1) & mask;
  end

  AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R2
  AST_RESTART_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !tick_o); // R2
endmodule

// File: rtl/rt_channel.sv
module rt_channel
  import rt_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int NUM_SEL    = 5,
  parameter int SHIFT_BASE = 2,
  parameter int SHIFT_STEP = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              restart_i,
  input  logic              wr_cnt_i,
  input  logic              wr_rld_i,
  input  logic              wr_ctrl_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  rld_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] cnt_q, rld_q;
  logic [SEL_W-1:0] sel_q;
  logic             ie_q, uf_q, tick, uf_evt;

  rt_prescaler #(
    .SEL_W(SEL_W), .NUM_SEL(NUM_SEL),
    .SHIFT_BASE(SHIFT_BASE), .SHIFT_STEP(SHIFT_STEP)
  ) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i),
    .restart_i(restart_i), .sel_i(sel_q), .tick_o(tick)
  );

  assign uf_evt = tick && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rld_q <= '0;
      sel_q <= '0;
      ie_q  <= 1'b0;
      uf_q  <= 1'b0;
    end else begin
      // software write has priority over reload/decrement
      if (wr_cnt_i)     cnt_q <= wdata_i;
      else if (uf_evt)  cnt_q <= rld_q;
      else if (tick)    cnt_q <= cnt_q - 1'b1;
      if (wr_rld_i) rld_q <= wdata_i;
      if (wr_ctrl_i) begin
        sel_q <= wdata_i[SEL_LSB +: SEL_W];
        ie_q  <= wdata_i[IE_BIT];
      end
      // set beats clear
      if (uf_evt)                          uf_q <= 1'b1;
      else if (wr_ctrl_i && !wdata_i[UF_BIT]) uf_q <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign rld_o  = rld_q;
  assign ctrl_o = {uf_q, ie_q, sel_q};
  assign irq_o  = uf_q & ie_q;

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick && !wr_cnt_i |=> $stable(cnt_q)); // R1
  AST_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && cnt_q != '0 && !wr_cnt_i |=> cnt_q == $past(cnt_q) - 1'b1); // R3
  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && cnt_q == '0 && !wr_cnt_i |=> cnt_q == $past(rld_q)); // R4
  AST_UF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && cnt_q == '0 |=> uf_q); // R5
  AST_UF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_q && !wr_ctrl_i |=> uf_q); // R6
  AST_SW_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt_i |=> cnt_q == $past(wdata_i)); // R8
endmodule

// File: rtl/rt_regif.sv
module rt_regif
  import rt_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  cnt_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  rld_i,
  input  logic [NUM_CH-1:0][CTRL_W-1:0]  ctrl_i,
  output logic [NUM_CH-1:0]              run_o,
  output logic [NUM_CH-1:0]              restart_o,
  output logic [NUM_CH-1:0]              wr_cnt_o,
  output logic [NUM_CH-1:0]              wr_rld_o,
  output logic [NUM_CH-1:0]              wr_ctrl_o,
  output logic [DATA_W-1:0]              rdata_o
);
  logic [NUM_CH-1:0] run_q;
  logic              wr_run;

  assign wr_run = we_i && (addr_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (wr_run) run_q <= wdata_i[NUM_CH-1:0];
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == '0) rdata_o[NUM_CH-1:0] = run_q;
    for (int c = 0; c < NUM_CH; c++) begin
      restart_o[c] = wr_run && wdata_i[c] && !run_q[c];
      wr_cnt_o[c]  = we_i && (int'(addr_i) == ch_addr(c, OFS_CNT));
      wr_rld_o[c]  = we_i && (int'(addr_i) == ch_addr(c, OFS_RLD));
      wr_ctrl_o[c] = we_i && (int'(addr_i) == ch_addr(c, OFS_CTRL));
      if (int'(addr_i) == ch_addr(c, OFS_CNT))  rdata_o = cnt_i[c];
      if (int'(addr_i) == ch_addr(c, OFS_RLD))  rdata_o = rld_i[c];
      if (int'(addr_i) == ch_addr(c, OFS_CTRL)) rdata_o = DATA_W'(ctrl_i[c]);
    end
  end

  assign run_o = run_q;

  AST_RUN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_run |=> run_q == $past(wdata_i[NUM_CH-1:0])); // R1
  AST_RUN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_run |=> $stable(run_q)); // R1
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import rt_pkg::*;
#(
  parameter int  NUM_CH     = 3,
  parameter int  DATA_W     = 32,
  parameter int  NUM_SEL    = 5,
  parameter int  SHIFT_BASE = 2,
  parameter int  SHIFT_STEP = 2,
  localparam int NUM_REGS   = 1 + REGS_PER_CH * NUM_CH,
  localparam int ADDR_W     = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] irq_o
);
  logic [NUM_CH-1:0][DATA_W-1:0] cnt, rld;
  logic [NUM_CH-1:0][CTRL_W-1:0] ctrl;
  logic [NUM_CH-1:0] run, restart, wr_cnt, wr_rld, wr_ctrl;

  rt_regif #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regif (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .cnt_i(cnt), .rld_i(rld), .ctrl_i(ctrl),
    .run_o(run), .restart_o(restart), .wr_cnt_o(wr_cnt),
    .wr_rld_o(wr_rld), .wr_ctrl_o(wr_ctrl), .rdata_o(rdata_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    rt_channel #(
      .CNT_W(DATA_W), .NUM_SEL(NUM_SEL),
      .SHIFT_BASE(SHIFT_BASE), .SHIFT_STEP(SHIFT_STEP)
    ) u_ch (
      .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run[c]),
      .restart_i(restart[c]), .wr_cnt_i(wr_cnt[c]),
      .wr_rld_i(wr_rld[c]), .wr_ctrl_i(wr_ctrl[c]), .wdata_i(wdata_i),
      .cnt_o(cnt[c]), .rld_o(rld[c]), .ctrl_o(ctrl[c]), .irq_o(irq_o[c])
    );
  end
endmodule

// File: tb/reload_timer_bench.sv
module reload_timer_bench;
  localparam int NCH = 3;
  localparam int AW  = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NCH-1:0] irq;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  reload_timer u_reload_timer (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  always #4 clk = ~clk;

  function automatic int a_cnt(int c);  return 1 + 3*c; endfunction
  function automatic int a_rld(int c);  return 2 + 3*c; endfunction
  function automatic int a_ctl(int c);  return 3 + 3*c; endfunction
  function automatic logic [31:0] ctl(bit uf, bit ie, int sel);
    return {27'd0, uf, ie, 3'(sel)};
  endfunction
  function automatic int ticks_for(int sel, int n);
    return (sel < 5) ? (n >> (2 + 2*sel)) : 0;
  endfunction
  // returns count; flag via output
  function automatic logic [31:0] model(logic [31:0] c0, logic [31:0] r,
                                        int nt, output bit f);
    logic [31:0] c = c0;
    f = 0;
    for (int i = 0; i < nt; i++) begin
      if (c == 0) begin c = r; f = 1; end
      else c = c - 1;
    end
    return c;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    addr = AW'(a); wdata = d; we = 1'b1;
    @(posedge clk); @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    addr = AW'(a); #1; d = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, e, keep;
    bit f;
    void'($urandom(32'd20240517));
    idle(3); rst_ni = 1'b1; idle(1);

    // R10 reset state
    for (int a = 0; a < 1 + 3*NCH; a++) begin
      rd(a, d); check(d == 0, "R10 reset reg", d, 0);
    end
    check(irq == 0, "R10 reset irq", 32'(irq), 0);

    // random runs, all channels at once
    for (int t = 0; t < 30; t++) begin
      int sel[NCH]; bit ie[NCH]; logic [31:0] c0[NCH], rv[NCH];
      int n;
      wr(0, 0);
      for (int c = 0; c < NCH; c++) begin
        sel[c] = ($urandom % 4 == 0) ? 5 + $urandom % 3 : $urandom % 5;
        ie[c]  = 1'($urandom);
        c0[c]  = $urandom % 40;
        rv[c]  = $urandom % 30;
        wr(a_cnt(c), c0[c]); wr(a_rld(c), rv[c]); wr(a_ctl(c), ctl(0, ie[c], sel[c]));
      end
      n = 1 + $urandom % 400;
      wr(0, 32'h7); idle(n - 1); wr(0, 0);
      for (int c = 0; c < NCH; c++) begin
        e = model(c0[c], rv[c], ticks_for(sel[c], n), f);
        rd(a_cnt(c), d);
        check(d == e, (sel[c] > 4) ? "R9 reserved count" : "R3 R4 count", d, e);
        rd(a_ctl(c), d);
        check(d[4] == f, "R5 flag", 32'(d[4]), 32'(f));
        check(irq[c] == (f & ie[c]), "R5 irq", 32'(irq[c]), 32'(f & ie[c]));
      end
    end

    // R1 freeze while stopped
    rd(a_cnt(1), keep); idle(50); rd(a_cnt(1), d);
    check(d == keep, "R1 frozen", d, keep);

    // R7 reload write while running
    wr(a_ctl(0), ctl(0, 0, 0)); wr(a_cnt(0), 1000); wr(a_rld(0), 3);
    wr(0, 1); idle(9); wr(a_rld(0), 77); idle(9); wr(0, 0);
    rd(a_cnt(0), d); check(d == 995, "R7 running", d, 995);
    wr(a_rld(0), 5); rd(a_cnt(0), d); check(d == 995, "R7 stopped", d, 995);

    // R8 software write collides with reload
    wr(a_cnt(0), 0); wr(a_rld(0), 50);
    wr(0, 1); idle(3); wr(a_cnt(0), 7); wr(0, 0);
    rd(a_cnt(0), d); check(d == 7, "R8 sw wins", d, 7);
    rd(a_ctl(0), d); check(d[4] == 1, "R8 flag set", 32'(d[4]), 1);

    // R6 sticky flag
    wr(a_ctl(0), ctl(1, 1, 0)); rd(a_ctl(0), d);
    check(d[4] == 1, "R6 write one keeps", 32'(d[4]), 1);
    check(irq[0] == 1, "R5 irq enabled", 32'(irq[0]), 1);
    wr(a_ctl(0), ctl(0, 1, 0)); rd(a_ctl(0), d);
    check(d[4] == 0, "R6 write zero clears", 32'(d[4]), 0);
    check(irq[0] == 0, "R6 irq cleared", 32'(irq[0]), 0);

    // R6 set beats clear: underflow on same edge as clearing write
    wr(a_cnt(0), 0); wr(0, 1); idle(3); wr(a_ctl(0), ctl(0, 0, 0)); wr(0, 0);
    rd(a_ctl(0), d); check(d[4] == 1, "R6 set wins", 32'(d[4]), 1);

    // R2 restart clears remainder
    wr(a_cnt(0), 100);
    wr(0, 1); idle(2); wr(0, 0);
    wr(0, 1); idle(2); wr(0, 0);
    rd(a_cnt(0), d); check(d == 100, "R2 remainder cleared", d, 100);
    wr(0, 1); idle(3); wr(0, 0);
    rd(a_cnt(0), d); check(d == 99, "R2 first tick", d, 99);

    // R2 largest shift boundary
    wr(a_ctl(2), ctl(0, 0, 4)); wr(a_cnt(2), 5);
    wr(0, 4); idle(1022); wr(0, 0);
    rd(a_cnt(2), d); check(d == 5, "R2 1023 clocks", d, 5);
    wr(0, 4); idle(1023); wr(0, 0);
    rd(a_cnt(2), d); check(d == 4, "R2 1024 clocks", d, 4);

    // R9 reserved code
    wr(a_ctl(1), ctl(0, 1, 6)); wr(a_cnt(1), 0);
    wr(0, 2); idle(100); wr(0, 0);
    rd(a_cnt(1), d); check(d == 0, "R9 reserved stop", d, 0);
    check(irq[1] == 0, "R9 no irq", 32'(irq[1]), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule